// File: doc/BRIEF.md
# Two-Variant Task Residency Tracker

This block follows the life of one hardware task that can be built in two ways. Each build has its own tile footprint and its own cost pair. The block watches the task's start request and its end pulse. It also takes three decisions from an outside controller: which build to start, whether to leave the build resident on its tiles after the run, and whether to give up a resident build.

From these inputs it keeps one of five states: idle, running build 1, running build 2, resident build 1 or resident build 2. For the current state it reports the tiles held, the configuration cost and the execution cost. The central rule is that restarting the build that is already resident costs nothing to configure. Starting from idle, or swapping to the other build, costs that build's full configuration charge. A resident build keeps its tiles even though it costs nothing while it waits.

A controller polls these outputs every cycle, so it can weigh keeping a build resident against releasing its tiles. This block does not choose the decisions and does not load any bitstreams.

Top module: `task_impl_tracker`

## Requirements
- R1: While reset is low, and in the first cycle after reset, state_o is 0 (idle), tiles_o is 0 and both cost outputs are 0.
- R2: In idle, a request enters the running state of the chosen build: sel_i=0 gives state 1 with configuration cost 50, and sel_i=1 gives state 2 with configuration cost 80.
- R3: While running, tiles_o shows the build's mask (4'b0001 for build 1, 4'b0011 for build 2) and exe_cost_o shows its execution cost (200 for build 1, 150 for build 2). cfg_cost_o holds the value it took on entry for as long as the run lasts.
- R4: An end pulse with keep_i=1 moves running build i to resident build i (state 3 for build 1, state 4 for build 2). The tile mask stays the same and both costs become 0.
- R5: An end pulse with keep_i=0 returns a running task to idle.
- R6: A request in resident state i that selects the same build enters running state i with configuration cost 0.
- R7: A request in resident state i that selects the other build enters that build's running state with its full configuration cost.
- R8: release_i in a resident state with no request returns the task to idle. When a request arrives in the same cycle, the request wins.
- R9: A request while running is ignored, including one that comes in the same cycle as the end pulse.
- R10: release_i in idle or while running has no effect, and an end pulse in idle or in a resident state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start request for the task |
| done_i | input | 1 | End-of-run pulse |
| sel_i | input | 1 | Build choice: 0 = build 1, 1 = build 2 |
| keep_i | input | 1 | Keep the build resident when the run ends |
| release_i | input | 1 | Give up a resident build |
| state_o | output | 3 | 0 idle, 1/2 running build 1/2, 3/4 resident build 1/2 |
| tiles_o | output | 4 | Tiles held, one bit per tile |
| cfg_cost_o | output | 16 | Configuration cost of the current state |
| exe_cost_o | output | 16 | Execution cost of the current state |

## Verification
Every output follows from one state register and one cost register, so a stimulus applied before a rising edge shows up in full after that edge. The bench drives inputs on the falling edge and compares all four outputs on the next falling edge, one edge later. Reset clears the outputs asynchronously, so the reset check is made a moment after reset goes low, with no clock edge needed.

// File: rtl/task_impl_tracker.sv
module task_impl_tracker #(
  parameter int TILES    = 4,
  parameter int COST_W   = 16,
  parameter logic [TILES-1:0] IMP1_MASK = 4'b0001,
  parameter logic [TILES-1:0] IMP2_MASK = 4'b0011,
  parameter int IMP1_CC  = 50,
  parameter int IMP1_EC  = 200,
  parameter int IMP2_CC  = 80,
  parameter int IMP2_EC  = 150
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              done_i,
  input  logic              sel_i,
  input  logic              keep_i,
  input  logic              release_i,
  output logic [2:0]        state_o,
  output logic [TILES-1:0]  tiles_o,
  output logic [COST_W-1:0] cfg_cost_o,
  output logic [COST_W-1:0] exe_cost_o
);

  localparam logic [2:0] ST_IDLE = 3'd0;
  localparam logic [2:0] ST_RUN1 = 3'd1;
  localparam logic [2:0] ST_RUN2 = 3'd2;
  localparam logic [2:0] ST_RES1 = 3'd3;
  localparam logic [2:0] ST_RES2 = 3'd4;

  localparam logic [COST_W-1:0] CC1 = COST_W'(IMP1_CC);
  localparam logic [COST_W-1:0] CC2 = COST_W'(IMP2_CC);
  localparam logic [COST_W-1:0] EC1 = COST_W'(IMP1_EC);
  localparam logic [COST_W-1:0] EC2 = COST_W'(IMP2_EC);
  localparam logic [COST_W-1:0] ZERO = '0;

  logic [2:0]        st_q, st_d;
  logic [COST_W-1:0] cfg_q, cfg_d;

  wire [2:0] run_pick = sel_i ? ST_RUN2 : ST_RUN1;

  always_comb begin
    st_d  = st_q;
    cfg_d = cfg_q;
    case (st_q)
      ST_IDLE: if (req_i) begin
        st_d  = run_pick;
        cfg_d = sel_i ? CC2 : CC1;
      end
      ST_RUN1: if (done_i) begin
        st_d  = keep_i ? ST_RES1 : ST_IDLE;
        cfg_d = ZERO;
      end
      ST_RUN2: if (done_i) begin
        st_d  = keep_i ? ST_RES2 : ST_IDLE;
        cfg_d = ZERO;
      end
      ST_RES1: if (req_i) begin
        st_d  = run_pick;
        cfg_d = sel_i ? CC2 : ZERO;
      end else if (release_i) begin
        st_d  = ST_IDLE;
      end
      ST_RES2: if (req_i) begin
        st_d  = run_pick;
        cfg_d = sel_i ? ZERO : CC1;
      end else if (release_i) begin
        st_d  = ST_IDLE;
      end
      default: begin
        st_d  = ST_IDLE;
        cfg_d = ZERO;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cfg_q <= ZERO;
    end else begin
      st_q  <= st_d;
      cfg_q <= cfg_d;
    end
  end

  wire holds1 = (st_q == ST_RUN1) || (st_q == ST_RES1);
  wire holds2 = (st_q == ST_RUN2) || (st_q == ST_RES2);

  assign state_o    = st_q;
  assign tiles_o    = holds1 ? IMP1_MASK : (holds2 ? IMP2_MASK : '0);
  assign cfg_cost_o = cfg_q;
  assign exe_cost_o = (st_q == ST_RUN1) ? EC1 : ((st_q == ST_RUN2) ? EC2 : ZERO);

  AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == ST_IDLE |-> tiles_o == '0 && cfg_cost_o == ZERO && exe_cost_o == ZERO); // R1
  AST_REUSE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_RES1 && req_i && !sel_i) |=> (state_o == ST_RUN1 && cfg_cost_o == ZERO)); // R6
  AST_SWAP_CHARGED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_RES1 && req_i && sel_i) |=> (state_o == ST_RUN2 && cfg_cost_o == CC2)); // R7
  AST_RUN_COST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == ST_RUN1 || state_o == ST_RUN2) && !done_i) |=> ($stable(state_o) && $stable(cfg_cost_o))); // R9
  AST_RESIDENT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_RES1 || state_o == ST_RES2) |-> (cfg_cost_o == ZERO && exe_cost_o == ZERO && tiles_o != '0)); // R4
  AST_END_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == ST_RUN1 || state_o == ST_RUN2) && done_i && !keep_i) |=> state_o == ST_IDLE); // R5
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == ST_RES1 || state_o == ST_RES2) && release_i && !req_i) |=> state_o == ST_IDLE); // R8

endmodule

// File: tb/test_task_impl_tracker.sv
module test_task_impl_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_i = 1'b0, done_i = 1'b0, sel_i = 1'b0, keep_i = 1'b0, release_i = 1'b0;
  logic [2:0]  state_o;
  logic [3:0]  tiles_o;
  logic [15:0] cfg_cost_o, exe_cost_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  task_impl_tracker i_task_impl_tracker (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .done_i(done_i), .sel_i(sel_i),
    .keep_i(keep_i), .release_i(release_i), .state_o(state_o), .tiles_o(tiles_o),
    .cfg_cost_o(cfg_cost_o), .exe_cost_o(exe_cost_o)
  );

  // {tag, req, done, sel, keep, release, state, tiles, cfg, exe}
  localparam logic [51:0] VEC [0:NV-1] = '{
    {8'd2,  5'b10000, 3'd1, 4'b0001, 16'd50, 16'd200}, // R2 idle -> run1
    {8'd3,  5'b00000, 3'd1, 4'b0001, 16'd50, 16'd200}, // R3 held
    {8'd9,  5'b10100, 3'd1, 4'b0001, 16'd50, 16'd200}, // R9 request ignored
    {8'd10, 5'b00001, 3'd1, 4'b0001, 16'd50, 16'd200}, // R10 release while running
    {8'd4,  5'b01010, 3'd3, 4'b0001, 16'd0,  16'd0},   // R4 keep build 1
    {8'd6,  5'b10000, 3'd1, 4'b0001, 16'd0,  16'd200}, // R6 reuse build 1
    {8'd3,  5'b00000, 3'd1, 4'b0001, 16'd0,  16'd200}, // R3 zero cost held
    {8'd4,  5'b01010, 3'd3, 4'b0001, 16'd0,  16'd0},   // R4
    {8'd7,  5'b10100, 3'd2, 4'b0011, 16'd80, 16'd150}, // R7 swap to build 2
    {8'd4,  5'b01010, 3'd4, 4'b0011, 16'd0,  16'd0},   // R4 keep build 2
    {8'd6,  5'b10100, 3'd2, 4'b0011, 16'd0,  16'd150}, // R6 reuse build 2
    {8'd5,  5'b01000, 3'd0, 4'b0000, 16'd0,  16'd0},   // R5 drop
    {8'd2,  5'b10100, 3'd2, 4'b0011, 16'd80, 16'd150}, // R2 idle -> run2
    {8'd4,  5'b01010, 3'd4, 4'b0011, 16'd0,  16'd0},   // R4
    {8'd8,  5'b00001, 3'd0, 4'b0000, 16'd0,  16'd0},   // R8 release
    {8'd2,  5'b10000, 3'd1, 4'b0001, 16'd50, 16'd200}, // R2
    {8'd4,  5'b01010, 3'd3, 4'b0001, 16'd0,  16'd0},   // R4
    {8'd8,  5'b10101, 3'd2, 4'b0011, 16'd80, 16'd150}, // R8 request beats release
    {8'd9,  5'b11000, 3'd0, 4'b0000, 16'd0,  16'd0},   // R9 request with end pulse
    {8'd10, 5'b00001, 3'd0, 4'b0000, 16'd0,  16'd0},   // R10 release in idle
    {8'd10, 5'b01010, 3'd0, 4'b0000, 16'd0,  16'd0},   // R10 end pulse in idle
    {8'd2,  5'b11100, 3'd2, 4'b0011, 16'd80, 16'd150}, // R2 end pulse in idle ignored
    {8'd4,  5'b01010, 3'd4, 4'b0011, 16'd0,  16'd0},   // R4
    {8'd10, 5'b01000, 3'd4, 4'b0011, 16'd0,  16'd0},   // R10 end pulse while resident
    {8'd7,  5'b10000, 3'd1, 4'b0001, 16'd50, 16'd200}, // R7 swap to build 1
    {8'd3,  5'b00010, 3'd1, 4'b0001, 16'd50, 16'd200}  // R3 keep alone does nothing
  };

  task automatic check(input int tag, input logic [2:0] es, input logic [3:0] et,
                       input logic [15:0] ec, input logic [15:0] ee);
    checks++;
    if (state_o !== es || tiles_o !== et || cfg_cost_o !== ec || exe_cost_o !== ee) begin
      fails++;
      $display("FAIL R%0d: got state=%0d tiles=%b cfg=%0d exe=%0d, expected state=%0d tiles=%b cfg=%0d exe=%0d",
               tag, state_o, tiles_o, cfg_cost_o, exe_cost_o, es, et, ec, ee);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #3;
    check(1, 3'd0, 4'b0000, 16'd0, 16'd0); // R1 during reset
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(1, 3'd0, 4'b0000, 16'd0, 16'd0); // R1 after reset
    for (int k = 0; k < NV; k++) begin
      {req_i, done_i, sel_i, keep_i, release_i} = VEC[k][43:39];
      @(negedge clk);
      check(int'(VEC[k][51:44]), VEC[k][38:36], VEC[k][35:32], VEC[k][31:16], VEC[k][15:0]);
    end
    // R1: reset in the middle of a run
    {req_i, done_i, sel_i, keep_i, release_i} = 5'b00000;
    rst_n = 1'b0;
    #1;
    check(1, 3'd0, 4'b0000, 16'd0, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    // R6 after reset: nothing is resident, so build 2 pays its full cost
    {req_i, sel_i} = 2'b11;
    @(negedge clk);
    check(2, 3'd2, 4'b0011, 16'd80, 16'd150);
    {req_i, sel_i} = 2'b00;
    done_i = 1'b1;
    @(negedge clk);
    check(5, 3'd0, 4'b0000, 16'd0, 16'd0);
    done_i = 1'b0;
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule